// File: doc/BRIEF.md
# DMA Channel Enable and Request-Mask Register Bank

This block keeps two per-channel bit vectors for a multi-channel DMA controller: an enable vector and a request-mask vector. Software changes each vector through a pair of write-one registers, one that sets bits and one that clears them, on a plain register bus made of an address, write data, a write strobe and registered read data. The enable vector and the mask vector can both be read back.

The transfer engine reports three kinds of events, and each one clears enable bits in hardware. A per-channel completion vector and a per-channel stop vector each clear the channels they flag. The stop vector is raised when a fetched descriptor carries a stop control code. A bus-error pulse clears the channel named by an index input. When a hardware clear and a software set reach the same channel in the same cycle, the clear wins.

The block combines the single and burst request lines of each channel with that channel's enable and mask bits. It then presents the effective request vector, registered, to the arbiter.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After a synchronous reset, the enable vector, the mask vector, `bus_rdata` and `req_out` are all zero.
- R2: A write to offset 0x0 sets the enable bit of every channel whose write-data bit is 1. Data bits that are 0 leave the channel unchanged.
- R3: A read returns its data in the cycle after the address is presented. Offset 0x0 returns the enable vector in bits 20:0 (1 = enabled), and bits 31:21 of every read are zero.
- R4: A write to offset 0x4 clears the enable bit of every channel whose data bit is 1. Reads of offset 0x4 return zero.
- R5: A write to offset 0x8 sets the mask bit of every channel whose data bit is 1 (1 = requests blocked). Reads of offset 0x8 return the mask vector.
- R6: A write to offset 0xC clears the mask bit of every channel whose data bit is 1. Data bits that are 0 have no effect, and reads of offset 0xC return zero.
- R7: When `evt_done[c]` is high, channel c's enable bit is clear from the next cycle on.
- R8: When `evt_stop[c]` is high, channel c's enable bit is clear from the next cycle on.
- R9: When `err_valid` is high, the channel indexed by `err_chan` is disabled. An index of 21 or more has no effect.
- R10: When a hardware clear and a software set reach the same channel in the same cycle, the channel ends up disabled.
- R11: `req_out[c]` is high in the cycle after channel c was enabled, unmasked, and had `sreq_in[c]` or `breq_in[c]` high. Otherwise it is low.
- R12: Write-data bits 31:21 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Registered read data |
| sreq_in | input | 21 | Single-transfer request lines |
| breq_in | input | 21 | Burst request lines |
| evt_done | input | 21 | Per-channel cycle-complete events |
| evt_stop | input | 21 | Per-channel descriptor-stop events |
| err_valid | input | 1 | Bus error on the active channel |
| err_chan | input | 5 | Index of the channel that saw the error |
| req_out | output | 21 | Effective per-channel request vector |

## Verification
A wrong enable or mask bit shows on `req_out` one cycle after any request reaches that channel. It also shows on `bus_rdata` one cycle after software reads offset 0x0 or 0x8. Comparing both outputs against a reference model on every clock therefore exposes a bad state transition within two cycles of the next request or read. The stimulus makes hardware clears collide with software sets, sends out-of-range error indices, and drives write data with the upper bits set, because these are the cases where a wrong priority or a missing guard would otherwise stay hidden.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int NUM_CH = 21;

  typedef enum logic [ADDR_W-1:0] {
    OFS_EN_SET  = 4'h0,
    OFS_EN_CLR  = 4'h4,
    OFS_MSK_SET = 4'h8,
    OFS_MSK_CLR = 4'hC
  } reg_ofs_e;
endpackage

// File: rtl/setclr_vec.sv
module setclr_vec #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  // Clears are applied after sets, so any clear wins a collision.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q | set_v) & ~clr_v & ~hw_clr;
  end
endmodule

// File: rtl/req_gate.sv
module req_gate #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] en,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] sreq,
  input  logic [W-1:0] breq,
  output logic [W-1:0] req
);
  always_ff @(posedge clk) begin
    if (rst) req <= '0;
    else     req <= en & ~mask & (sreq | breq);
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int NCH   = NUM_CH,
  parameter int CH_W  = $clog2(NCH),
  parameter int DW    = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_we,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    sreq_in,
  input  logic [NCH-1:0]    breq_in,
  input  logic [NCH-1:0]    evt_done,
  input  logic [NCH-1:0]    evt_stop,
  input  logic              err_valid,
  input  logic [CH_W-1:0]   err_chan,
  output logic [NCH-1:0]    req_out
);
  localparam int PAD_W = DW - NCH;

  logic [NCH-1:0] wbits;
  logic [NCH-1:0] en_set, en_clr, msk_set, msk_clr;
  logic [NCH-1:0] err_vec, hw_clr, no_clr;
  logic [NCH-1:0] en_q, mask_q;

  // Bits above the channel count are dropped here.
  assign wbits = bus_wdata[NCH-1:0];

  always_comb begin
    en_set  = '0;
    en_clr  = '0;
    msk_set = '0;
    msk_clr = '0;
    if (bus_we) begin
      case (bus_addr)
        OFS_EN_SET:  en_set  = wbits;
        OFS_EN_CLR:  en_clr  = wbits;
        OFS_MSK_SET: msk_set = wbits;
        OFS_MSK_CLR: msk_clr = wbits;
        default: ;
      endcase
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_err
      assign err_vec[gi] = err_valid && (err_chan == CH_W'(gi));
    end
  endgenerate

  assign hw_clr = evt_done | evt_stop | err_vec;
  assign no_clr = '0;

  setclr_vec #(.W(NCH)) u_en (
    .clk(clk), .rst(rst), .set_v(en_set), .clr_v(en_clr),
    .hw_clr(hw_clr), .q(en_q)
  );

  setclr_vec #(.W(NCH)) u_mask (
    .clk(clk), .rst(rst), .set_v(msk_set), .clr_v(msk_clr),
    .hw_clr(no_clr), .q(mask_q)
  );

  req_gate #(.W(NCH)) u_gate (
    .clk(clk), .rst(rst), .en(en_q), .mask(mask_q),
    .sreq(sreq_in), .breq(breq_in), .req(req_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        OFS_EN_SET:  bus_rdata <= {{PAD_W{1'b0}}, en_q};
        OFS_MSK_SET: bus_rdata <= {{PAD_W{1'b0}}, mask_q};
        default:     bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int NCH  = 21,
  parameter int CH_W = 5,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [DW-1:0]   bus_rdata,
  input logic [NCH-1:0]  evt_done,
  input logic [NCH-1:0]  evt_stop,
  input logic            err_valid,
  input logic [CH_W-1:0] err_chan,
  input logic [NCH-1:0]  en_q,
  input logic [NCH-1:0]  mask_q,
  input logic [NCH-1:0]  req_out
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (en_q == '0 && mask_q == '0 && req_out == '0 && bus_rdata == '0));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DW-1:NCH] == '0);

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (|evt_done) |=> ((en_q & $past(evt_done)) == '0));

  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (|evt_stop) |=> ((en_q & $past(evt_stop)) == '0));

  assert_err_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (err_valid && int'(err_chan) < NCH) |=> (en_q[$past(err_chan)] == 1'b0));

  assert_req_gated_R11: assert property (@(posedge clk) disable iff (rst)
    (|req_out) |-> ((req_out & ~($past(en_q) & ~$past(mask_q))) == '0));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.NCH(NCH), .CH_W(CH_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_rdata(bus_rdata), .evt_done(evt_done),
  .evt_stop(evt_stop), .err_valid(err_valid), .err_chan(err_chan),
  .en_q(en_q), .mask_q(mask_q), .req_out(req_out)
);

// File: tb/tb_dma_chan_ctrl.sv
`timescale 1ns/1ps
module tb_dma_chan_ctrl;
  localparam int N = 21;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [N-1:0] sreq_in, breq_in, evt_done, evt_stop, req_out;
  logic        err_valid;
  logic [4:0]  err_chan;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [N-1:0] m_en, m_mask, x_req;
  logic [31:0]  x_rdata;

  always #10 clk = ~clk;

  dma_chan_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .sreq_in(sreq_in),
    .breq_in(breq_in), .evt_done(evt_done), .evt_stop(evt_stop),
    .err_valid(err_valid), .err_chan(err_chan), .req_out(req_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Advance one clock, updating the reference model from the driven inputs.
  task automatic step(string tag);
    logic [N-1:0] hw, w;
    w  = bus_wdata[N-1:0];
    hw = evt_done | evt_stop;
    if (err_valid && err_chan < 5'd21) hw[err_chan] = 1'b1;
    if (rst) begin
      x_rdata = 0; x_req = 0; m_en = 0; m_mask = 0;
    end else begin
      x_rdata = (bus_addr == 4'h0) ? {11'b0, m_en} :
                (bus_addr == 4'h8) ? {11'b0, m_mask} : 32'h0;
      x_req = m_en & ~m_mask & (sreq_in | breq_in);
      if (bus_we && bus_addr == 4'h0) m_en   = m_en | w;
      if (bus_we && bus_addr == 4'h4) m_en   = m_en & ~w;
      if (bus_we && bus_addr == 4'h8) m_mask = m_mask | w;
      if (bus_we && bus_addr == 4'hC) m_mask = m_mask & ~w;
      m_en = m_en & ~hw;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " rdata"}, bus_rdata, x_rdata);
    check({tag, " req"}, {11'b0, req_out}, {11'b0, x_req});
  endtask

  task automatic idle();
    bus_we = 0; bus_addr = 4'h4; bus_wdata = 0;
    sreq_in = 0; breq_in = 0; evt_done = 0; evt_stop = 0;
    err_valid = 0; err_chan = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, string tag);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    step(tag);
    idle();
  endtask

  task automatic rd(logic [3:0] a, string tag);
    bus_we = 0; bus_addr = a;
    step(tag);
    idle();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_mask = 0;
    idle();
    rst = 1;
    @(negedge clk);
    step("R1 reset");
    step("R1 reset");
    rst = 0;
    rd(4'h0, "R1 enable zero");
    rd(4'h8, "R1 mask zero");

    // R2 / R3 / R12: set with upper bits, read back
    wr(4'h0, 32'hFFE0_0005, "R2 set");
    rd(4'h0, "R3 read enable");
    wr(4'h0, 32'h0000_0000, "R2 zero no effect");
    wr(4'h0, 32'hFFFF_FFFF, "R12 upper bits ignored");
    rd(4'h0, "R12 read all");
    rd(4'h4, "R4 clr reads zero");
    // R4 clear
    wr(4'h4, 32'h0010_0003, "R4 clear");
    rd(4'h0, "R4 read after clear");

    // R5 / R6 mask
    wr(4'h8, 32'h0000_00F0, "R5 mask set");
    rd(4'h8, "R5 read mask");
    wr(4'hC, 32'h0000_0030, "R6 mask clear");
    wr(4'hC, 32'h0000_0000, "R6 zero no effect");
    rd(4'h8, "R6 read mask");
    rd(4'hC, "R6 reads zero");

    // R11 requests in several patterns
    sreq_in = 21'h1F_FFFF; step("R11 sreq all");
    breq_in = 21'h0A_AAAA; step("R11 breq");
    sreq_in = 21'h00_00C0; breq_in = 21'h00_0100; step("R11 masked");
    idle(); step("R11 idle");

    // R7 / R8 / R9 hardware clears
    evt_done = 21'h00_0400; sreq_in = 21'h1F_FFFF; step("R7 done");
    evt_stop = 21'h10_0000; step("R8 stop");
    idle();
    err_valid = 1; err_chan = 5'd9; step("R9 err");
    err_chan = 5'd25; step("R9 err out of range");
    idle();
    rd(4'h0, "R9 read enable");

    // R10 collision of hardware clear and software set
    bus_we = 1; bus_addr = 4'h0; bus_wdata = 32'h0000_0C00;
    evt_done = 21'h00_0800; step("R10 race done");
    idle();
    bus_we = 1; bus_addr = 4'h0; bus_wdata = 32'h0000_0003;
    err_valid = 1; err_chan = 5'd1; step("R10 race err");
    idle();
    rd(4'h0, "R10 read enable");
    sreq_in = 21'h1F_FFFF; step("R11 final");
    idle();

    // mixed activity
    for (int i = 0; i < 40; i++) begin
      bus_we = i[0]; bus_addr = 4'(i[2:1] * 4);
      bus_wdata = 32'h9E37_79B9 * i;
      sreq_in = 21'(i * 12345); breq_in = 21'(i * 777);
      evt_done = (i % 5 == 0) ? 21'(1 << (i % 21)) : 21'h0;
      evt_stop = (i % 7 == 0) ? 21'(1 << ((i + 3) % 21)) : 21'h0;
      err_valid = (i % 3 == 0); err_chan = 5'(i);
      step("R2-mix");
    end
    idle();
    rst = 1; step("R1 re-reset"); rst = 0;
    rd(4'h0, "R1 after re-reset");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule